// File: doc/BRIEF.md
# Four-Channel Scan Sequencer

This block assigns a channel number to each sample produced by a four-input sampler. A 3-bit mode code is stored in the block. It selects one of four legal scan shapes: a single channel, the lower pair (channels 0 and 1), the upper pair (channels 2 and 3), or all four channels in ascending order. Code 0 leaves the sequencer idle. Each pulse on the sample strobe gives one registered output beat, one cycle later. The beat carries the channel index, a start-of-scan flag and the coupling bit of that channel's pair. The scan position then moves to the next channel of the pattern.

Writing a new mode code, or pulsing restart, moves the scan back to the first channel of the pattern. A separate combinational checker takes a requested start channel and channel count. It reports whether the hardware can perform that request, and if it can, which mode code implements it.

Top module: `scan_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `smp_valid` and `smp_first` are 0 and `smp_chan` is 0.
- R2: With a stored mode code of binary 1xx, every sample beat carries the channel given by the two low bits of the code, and every beat has `smp_first` set.
- R3: With mode code 2, sample beats carry channels 0, 1, 0, 1 and so on.
- R4: With mode code 3, sample beats carry channels 2, 3, 2, 3 and so on.
- R5: With mode code 1, sample beats carry channels 0, 1, 2, 3 in ascending order and then repeat.
- R6: With mode code 0, no sample beat is produced, whatever the strobe does.
- R7: A cycle with `mode_wr` or `scan_restart` high moves the scan to the first channel of the pattern. A strobe in that same cycle produces no beat. `mode_wr` takes precedence over `scan_restart`.
- R8: `smp_first` is 1 exactly on beats that carry the first channel of the pattern, and it is 0 whenever `smp_valid` is 0.
- R9: `smp_valid` rises for exactly one cycle, in the cycle after a strobe that is accepted. An accepted strobe is one in a cycle with no mode write and no restart, while the stored mode is not idle.
- R10: A request whose start channel plus channel count exceeds 4, or whose count is 0, sets `req_bad`.
- R11: A request with a channel count of 3 sets `req_bad`.
- R12: A request for two channels that starts at channel 1 sets `req_bad`.
- R13: For a legal request, `req_mode` is the code that implements it: 4 plus the start channel for one channel, 2 for channels 0–1, 3 for channels 2–3, 1 for all four. When `req_bad` is 1, `req_mode` is 0.
- R14: On each beat, `smp_ac` is the bit of `ac_pair` that belongs to the beat's channel. Bit 0 serves channels 0 and 1; bit 1 serves channels 2 and 3. The bit is sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Store `mode_in` and move the scan back to its first channel |
| mode_in | input | 3 | Mode code to store |
| scan_restart | input | 1 | Move the scan back to the first channel of the stored pattern |
| smp_strobe | input | 1 | One sample has been converted |
| ac_pair | input | 2 | AC-coupling bit per channel pair |
| smp_valid | output | 1 | Sample beat is present |
| smp_chan | output | 2 | Channel index of the beat |
| smp_first | output | 1 | Beat carries the first channel of the scan |
| smp_ac | output | 1 | Coupling bit of the beat's channel pair |
| req_start | input | 2 | Requested start channel |
| req_count | input | 3 | Requested number of channels |
| req_bad | output | 1 | Request cannot be performed |
| req_mode | output | 3 | Mode code that implements a legal request, else 0 |

## Verification
The assertions check the following on every cycle:
- a beat never appears without an accepted strobe in the cycle before;
- an idle mode never yields a beat;
- every beat's channel lies inside the pattern that was stored when the strobe arrived;
- the first beat after a mode write or restart is flagged as a scan start;
- the coupling bit comes from the pair the channel belongs to;
- the three illegal-request rules always raise the flag.

Only the bench scenarios can show the exact channel order over several scans of each mode, and the wrap-around back to the first channel. The same holds for the exact code returned for every legal request.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int MODE_W  = 3;
  localparam int CNT_W   = $clog2(NUM_CH) + 1;

  typedef struct packed {
    logic              idle;
    logic [CH_W-1:0]   first;
    logic [CNT_W-1:0]  len;
  } pattern_t;

  // Mode code to scan pattern: 1xx single, 010 low pair, 011 high pair,
  // 001 all four, 000 idle.
  function automatic pattern_t mode_to_pattern(input logic [MODE_W-1:0] code);
    pattern_t p;
    p.idle  = 1'b0;
    p.first = '0;
    p.len   = CNT_W'(1);
    if (code[2]) begin
      p.first = code[CH_W-1:0];
      p.len   = CNT_W'(1);
    end else begin
      case (code[1:0])
        2'd0: begin p.idle = 1'b1; p.len = '0; end
        2'd1: begin p.first = '0;          p.len = CNT_W'(NUM_CH); end
        2'd2: begin p.first = '0;          p.len = CNT_W'(2); end
        default: begin p.first = CH_W'(2); p.len = CNT_W'(2); end
      endcase
    end
    return p;
  endfunction

  // Legality of a start/count request.
  function automatic logic request_legal(input logic [CH_W-1:0] start,
                                         input logic [CNT_W-1:0] count);
    logic [CNT_W:0] span;
    span = {1'b0, count} + (CNT_W+1)'(start);
    if (count == '0)                              return 1'b0;
    if (span > (CNT_W+1)'(NUM_CH))                return 1'b0;
    if (count == CNT_W'(3))                       return 1'b0;
    if (count == CNT_W'(2) && start == CH_W'(1))  return 1'b0;
    return 1'b1;
  endfunction

  // Mode code for a request already known to be legal.
  function automatic logic [MODE_W-1:0] request_code(input logic [CH_W-1:0] start,
                                                     input logic [CNT_W-1:0] count);
    logic [MODE_W-1:0] c;
    if (count == CNT_W'(1))        c = {1'b1, start};
    else if (count == CNT_W'(2))   c = start[1] ? 3'd3 : 3'd2;
    else                           c = 3'd1;
    return c;
  endfunction

endpackage

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
  import scan_seq_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              idle,
  output logic [CH_W-1:0]   first,
  output logic [CNT_W-1:0]  len
);
  pattern_t pat;

  always_comb begin
    pat   = mode_to_pattern(mode);
    idle  = pat.idle;
    first = pat.first;
    len   = pat.len;
  end
endmodule

// File: rtl/scan_position.sv
module scan_position
  import scan_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] len,
  output logic [CH_W-1:0]  pos,
  output logic             at_first
);
  logic [CNT_W-1:0] nxt;
  logic             wrap;

  assign nxt      = CNT_W'(pos) + CNT_W'(1);
  assign wrap     = (nxt >= len);
  assign at_first = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        pos <= '0;
    else if (clear)    pos <= '0;
    else if (advance)  pos <= wrap ? '0 : nxt[CH_W-1:0];
  end
endmodule

// File: rtl/scan_request_check.sv
module scan_request_check
  import scan_seq_pkg::*;
(
  input  logic [CH_W-1:0]   start,
  input  logic [CNT_W-1:0]  count,
  output logic              bad,
  output logic [MODE_W-1:0] code
);
  logic ok;

  always_comb begin
    ok   = request_legal(start, count);
    bad  = ~ok;
    code = ok ? request_code(start, count) : '0;
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int NPAIR = NUM_CH / 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              scan_restart,
  input  logic              smp_strobe,
  input  logic [NPAIR-1:0]  ac_pair,
  output logic              smp_valid,
  output logic [CH_W-1:0]   smp_chan,
  output logic              smp_first,
  output logic              smp_ac,
  input  logic [CH_W-1:0]   req_start,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_bad,
  output logic [MODE_W-1:0] req_mode
);
  localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [MODE_W-1:0] mode_q;
  logic              pat_idle;
  logic [CH_W-1:0]   pat_first;
  logic [CNT_W-1:0]  pat_len;
  logic [CH_W-1:0]   pos;
  logic              pos_first;
  logic              scan_clear;
  logic              accept;
  logic [CH_W-1:0]   cur_chan;
  logic [PAIR_W-1:0] cur_pair;
  logic [NPAIR-1:0]  pair_hit;
  logic              cur_ac;

  assign scan_clear = mode_wr | scan_restart;
  assign accept     = smp_strobe & ~scan_clear & ~pat_idle;
  assign cur_chan   = pat_first + pos;
  assign cur_pair   = PAIR_W'(cur_chan >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_in;
  end

  scan_mode_decode u_dec (
    .mode  (mode_q),
    .idle  (pat_idle),
    .first (pat_first),
    .len   (pat_len)
  );

  scan_position u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (scan_clear),
    .advance  (accept),
    .len      (pat_len),
    .pos      (pos),
    .at_first (pos_first)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign pair_hit[g] = (cur_pair == PAIR_W'(g)) & ac_pair[g];
  end
  assign cur_ac = |pair_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_chan  <= '0;
      smp_first <= 1'b0;
      smp_ac    <= 1'b0;
    end else begin
      smp_valid <= accept;
      smp_first <= accept & pos_first;
      if (accept) begin
        smp_chan <= cur_chan;
        smp_ac   <= cur_ac;
      end
    end
  end

  scan_request_check u_req (
    .start (req_start),
    .count (req_count),
    .bad   (req_bad),
    .code  (req_mode)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
  import scan_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic              scan_restart,
  input logic              smp_strobe,
  input logic [1:0]        ac_pair,
  input logic              smp_valid,
  input logic [CH_W-1:0]   smp_chan,
  input logic              smp_first,
  input logic              smp_ac,
  input logic [CH_W-1:0]   req_start,
  input logic [CNT_W-1:0]  req_count,
  input logic              req_bad,
  input logic [MODE_W-1:0] req_mode,
  input logic              pat_idle,
  input logic [CH_W-1:0]   pat_first,
  input logic [CNT_W-1:0]  pat_len
);
  logic await_first;

  always_ff @(posedge clk) begin
    if (!rst_n)                        await_first <= 1'b1;
    else if (mode_wr || scan_restart)  await_first <= 1'b1;
    else if (smp_valid)                await_first <= 1'b0;
  end

  AST_BEAT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(smp_strobe && !mode_wr && !scan_restart)); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !$past(pat_idle)); // R6

  AST_CHAN_IN_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ({1'b0, smp_chan} >= {1'b0, $past(pat_first)}) &&
                  (CNT_W'(smp_chan) < CNT_W'($past(pat_first)) + $past(pat_len))); // R5

  AST_FIRST_FLAG_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_first |-> smp_valid && (smp_chan == $past(pat_first))); // R8

  AST_FIRST_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && await_first) |-> smp_first); // R7

  AST_PAIR_COUPLING: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> smp_ac == (smp_chan[1] ? $past(ac_pair[1]) : $past(ac_pair[0]))); // R14

  AST_OVERRUN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((CNT_W+1)'(req_start) + (CNT_W+1)'(req_count) > (CNT_W+1)'(NUM_CH)) |-> req_bad); // R10

  AST_COUNT3_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_count == CNT_W'(3)) |-> req_bad); // R11

  AST_PAIR_AT1_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_count == CNT_W'(2) && req_start == CH_W'(1)) |-> req_bad); // R12

  AST_BAD_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |-> (req_mode == '0)); // R13
endmodule

bind scan_sequencer scan_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_wr      (mode_wr),
  .scan_restart (scan_restart),
  .smp_strobe   (smp_strobe),
  .ac_pair      (ac_pair),
  .smp_valid    (smp_valid),
  .smp_chan     (smp_chan),
  .smp_first    (smp_first),
  .smp_ac       (smp_ac),
  .req_start    (req_start),
  .req_count    (req_count),
  .req_bad      (req_bad),
  .req_mode     (req_mode),
  .pat_idle     (pat_idle),
  .pat_first    (pat_first),
  .pat_len      (pat_len)
);

// File: tb/scan_sequencer_tb_top.sv
`timescale 1ns/1ps
module scan_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_in = 3'd0;
  logic       scan_restart = 1'b0;
  logic       smp_strobe = 1'b0;
  logic [1:0] ac_pair = 2'b00;
  logic       smp_valid, smp_first, smp_ac;
  logic [1:0] smp_chan;
  logic [1:0] req_start = 2'd0;
  logic [2:0] req_count = 3'd1;
  logic       req_bad;
  logic [2:0] req_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  int m_mode = 0;
  int m_pos = 0;
  int e_valid = 0, e_chan = 0, e_first = 0, e_ac = 0;

  always #2.5 clk = ~clk;

  scan_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .scan_restart(scan_restart), .smp_strobe(smp_strobe), .ac_pair(ac_pair),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_first(smp_first),
    .smp_ac(smp_ac), .req_start(req_start), .req_count(req_count),
    .req_bad(req_bad), .req_mode(req_mode)
  );

  function automatic int pat_len_of(input int m);
    if (m >= 4) return 1;
    if (m == 1) return 4;
    if (m == 0) return 0;
    return 2;
  endfunction

  function automatic int pat_first_of(input int m);
    if (m >= 4) return m - 4;
    return (m == 3) ? 2 : 0;
  endfunction

  function automatic int legal_code(input int s, input int c);
    if (c == 1) return 4 + s;
    if (c == 2 && s == 0) return 2;
    if (c == 2 && s == 2) return 3;
    if (c == 4 && s == 0) return 1;
    return 0;
  endfunction

  function automatic string mode_tag(input int m);
    if (m >= 4) return "R2";
    if (m == 1) return "R5";
    if (m == 2) return "R3";
    if (m == 3) return "R4";
    return "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit wr, input int code, input bit rs, input bit st, input int ac);
    int prev_mode;
    @(negedge clk);
    mode_wr = wr; mode_in = 3'(code); scan_restart = rs;
    smp_strobe = st; ac_pair = 2'(ac);
    prev_mode = m_mode;
    if (wr) begin
      m_mode = code; m_pos = 0; e_valid = 0; e_first = 0;
    end else if (rs) begin
      m_pos = 0; e_valid = 0; e_first = 0;
    end else if (st && m_mode != 0) begin
      e_valid = 1;
      e_chan  = pat_first_of(m_mode) + m_pos;
      e_first = (m_pos == 0);
      e_ac    = (ac >> (e_chan / 2)) & 1;
      m_pos   = (m_pos + 1 >= pat_len_of(m_mode)) ? 0 : m_pos + 1;
    end else begin
      e_valid = 0; e_first = 0;
    end
    @(posedge clk);
    #1;
    if (wr || rs) check("R7", smp_valid, 0);
    else if (st && prev_mode == 0) check("R6", smp_valid, 0);
    else check("R9", smp_valid, e_valid);
    check("R8", smp_first, e_first);
    if (e_valid) begin
      check(mode_tag(prev_mode), smp_chan, e_chan);
      check("R14", smp_ac, e_ac);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #1;
    check("R1", smp_valid, 0);
    check("R1", smp_first, 0);
    check("R1", smp_chan, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", smp_valid, 0);

    // R6: idle after reset, strobes ignored
    repeat (3) cyc(0, 0, 0, 1, 0);
    // R2 single channel 1
    cyc(1, 5, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 1, 1);
    // R3 low pair
    cyc(1, 2, 0, 0, 0);
    repeat (5) cyc(0, 0, 0, 1, 2);
    // R4 high pair with coupling bits
    cyc(1, 3, 0, 0, 0);
    repeat (5) cyc(0, 0, 0, 1, 2);
    // R5 all four, then R7 restart mid-scan with strobe held
    cyc(1, 1, 0, 0, 0);
    repeat (6) cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 1, 1, 3);
    repeat (5) cyc(0, 0, 0, 1, 3);
    // R7 mode write beats restart, strobe in same cycle dropped
    cyc(1, 7, 1, 1, 3);
    repeat (2) cyc(0, 0, 0, 1, 2);
    cyc(1, 0, 0, 0, 0);
    repeat (2) cyc(0, 0, 0, 1, 0);

    // request check, every start/count pair (R10-R13)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        int code;
        @(negedge clk);
        req_start = 2'(s); req_count = 3'(c);
        #1;
        code = legal_code(s, c);
        if (c == 3) check("R11", req_bad, 1);
        else if (c == 2 && s == 1) check("R12", req_bad, 1);
        else if (c == 0 || s + c > 4) check("R10", req_bad, 1);
        else check("R13", req_bad, 0);
        check("R13", req_mode, code);
      end
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r1, r2;
      r1 = $urandom_range(0, 99);
      r2 = $urandom_range(0, 99);
      cyc(r1 < 5, $urandom_range(0, 7), (r1 >= 5 && r1 < 10) || r2 < 2,
          r2 < 65, $urandom_range(0, 3));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule